// File: doc/BRIEF.md
# Interrupt Enable and Dispatch Gate

This block sits between the interrupt flag sources of a small controller and its instruction sequencer. It collects seven request lines: two external inputs, two timer overflows, a serial port, a real-time clock and a power-fail monitor. Each request is masked by its own enable bit and by a global enable. The power-fail request obeys only its own enable. On a machine-cycle strobe the block picks one eligible request. It then raises a single-clock acknowledge together with the source index and that source's jump address.

After an acknowledge the block counts a service routine as active. It dispatches nothing more until the sequencer pulses the return-from-interrupt input. The block keeps the two timer overflow flags itself. An overflow pulse sets its flag, and the flag clears by hardware at the edge where that timer is dispatched. Every other request line is held by its own source, and the block only samples it.

Top module: `irq_dispatch_gate`

## Requirements
- R1: After reset, `ack_o` is 0, `in_svc_o` is 0 and both bits of `tmr_flag_o` are 0.
- R2: A source whose bit in `en_i` is 0 is never acknowledged.
- R3: While `glb_en_i` is 0, no source other than power-fail (index 6) is acknowledged.
- R4: Power-fail (index 6) is dispatched while `glb_en_i` is 0 if `en_i[6]` is 1, and it is not dispatched if `en_i[6]` is 0.
- R5: Source indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, real-time clock = 5, power-fail = 6. Among the eligible requests, power-fail wins first. Otherwise the lowest index wins, and it appears on `ack_idx_o`.
- R6: With an acknowledge, `vec_o` equals 0x0003 + 8 × index (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B, 0x33).
- R7: A dispatch happens only at a clock edge where `mc_stb_i` is 1. `ack_o` is then high for exactly the one following clock.
- R8: `in_svc_o` rises with the acknowledge and stays high until an edge that samples `reti_i` = 1. While it is high, no request is acknowledged.
- R9: A pulse on `tmr_ovf_i[k]` sets `tmr_flag_o[k]`. The flag is the only request for timer k, and `req_i` bits 1 and 3 are ignored. The flag reads 0 in the cycle in which that timer's acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_stb_i | input | 1 | Machine-cycle strobe; dispatch is sampled here |
| req_i | input | 7 | Held request lines, one bit per source index |
| tmr_ovf_i | input | 2 | Timer 0/1 overflow pulses |
| en_i | input | 7 | Per-source enable bits |
| glb_en_i | input | 1 | Global enable (does not gate power-fail) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| ack_o | output | 1 | One-clock acknowledge |
| ack_idx_o | output | 3 | Index of the acknowledged source |
| vec_o | output | 16 | Jump address of the acknowledged source |
| in_svc_o | output | 1 | Service routine active |
| tmr_flag_o | output | 2 | Timer 0/1 pending flags |

## Verification
The picker is driven first with single requests and then with mixed sets. The mixed sets are external 1, serial and real-time clock together, and a low index together with power-fail. Together these separate lowest-index ordering from the power-fail override. A mask-off case for each kind of enable, individual and global, has power-fail present and absent, which shows that the global enable skips exactly one source. The timer tests hold the raw timer request bits high while the flags are clear, then set one flag and then both. They show that only the internal flags request service and that each flag clears on its own dispatch. Requests held high between strobes, and strobes during an active service, show that dispatch needs both the strobe and the idle state.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned NSRC_DEF     = 7;
  localparam int unsigned VEC_W_DEF    = 16;
  localparam int unsigned VEC_BASE_DEF = 3;
  localparam int unsigned VEC_STEP_DEF = 8;
  localparam int unsigned T0_IDX_DEF   = 1;
  localparam int unsigned T1_IDX_DEF   = 3;

  typedef enum logic {SVC_IDLE = 1'b0, SVC_BUSY = 1'b1} svc_state_e;
endpackage

// File: rtl/irq_tmr_flags.sv
module irq_tmr_flags #(
  parameter int unsigned N_TMR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_TMR-1:0] ovf_i,
  input  logic [N_TMR-1:0] clr_i,
  output logic [N_TMR-1:0] flag_o
);
  for (genvar t = 0; t < N_TMR; t++) begin : g_flag
    logic flag_q;
    // set wins so an overflow coinciding with dispatch is not lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (ovf_i[t]) flag_q <= 1'b1;
      else if (clr_i[t]) flag_q <= 1'b0;
    end
    assign flag_o[t] = flag_q;

    assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[t] && !ovf_i[t]) |=> !flag_o[t]);
  end
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned PF_IDX = N_SRC - 1
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             glb_en_i,
  output logic [N_SRC-1:0] elig_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    if (g == PF_IDX) begin : g_pf
      assign elig_o[g] = pend_i[g] & en_i[g];
    end else begin : g_std
      assign elig_o[g] = pend_i[g] & en_i[g] & glb_en_i;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC    = 7,
  parameter int unsigned PF_IDX   = N_SRC - 1,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8,
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = IDX_W'(i);
    end
    if (elig_i[PF_IDX]) idx_o = IDX_W'(PF_IDX);
  end

  assign any_o = |elig_i;
  assign vec_o = VEC_W'(VEC_BASE) + VEC_W'(idx_o) * VEC_W'(VEC_STEP);

  always_comb begin
    if (any_o) assert_pick_eligible_R5: assert (elig_i[idx_o]);
  end
endmodule

// File: rtl/irq_dispatch_gate.sv
module irq_dispatch_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned N_SRC    = NSRC_DEF,
  parameter int unsigned VEC_W    = VEC_W_DEF,
  parameter int unsigned VEC_BASE = VEC_BASE_DEF,
  parameter int unsigned VEC_STEP = VEC_STEP_DEF,
  parameter int unsigned T0_IDX   = T0_IDX_DEF,
  parameter int unsigned T1_IDX   = T1_IDX_DEF,
  localparam int unsigned PF_IDX  = N_SRC - 1,
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mc_stb_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [1:0]       tmr_ovf_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             glb_en_i,
  input  logic             reti_i,
  output logic             ack_o,
  output logic [IDX_W-1:0] ack_idx_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             in_svc_o,
  output logic [1:0]       tmr_flag_o
);
  logic [N_SRC-1:0] pend, elig;
  logic             any;
  logic [IDX_W-1:0] pick_idx;
  logic [VEC_W-1:0] pick_vec;
  logic             fire;
  logic [1:0]       tmr_clr;
  svc_state_e       svc_q;
  logic             ack_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  // timer bits come from internal flags, raw lines elsewhere
  for (genvar s = 0; s < N_SRC; s++) begin : g_pend
    if (s == T0_IDX) begin : g_t0
      assign pend[s] = tmr_flag_o[0];
    end else if (s == T1_IDX) begin : g_t1
      assign pend[s] = tmr_flag_o[1];
    end else begin : g_raw
      assign pend[s] = req_i[s];
    end
  end

  irq_mask #(.N_SRC(N_SRC), .PF_IDX(PF_IDX)) i_mask (
    .pend_i  (pend),
    .en_i    (en_i),
    .glb_en_i(glb_en_i),
    .elig_o  (elig)
  );

  irq_pick #(
    .N_SRC(N_SRC), .PF_IDX(PF_IDX), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) i_pick (
    .elig_i(elig),
    .any_o (any),
    .idx_o (pick_idx),
    .vec_o (pick_vec)
  );

  assign fire       = mc_stb_i && (svc_q == SVC_IDLE) && any;
  assign tmr_clr[0] = fire && (pick_idx == IDX_W'(T0_IDX));
  assign tmr_clr[1] = fire && (pick_idx == IDX_W'(T1_IDX));

  irq_tmr_flags #(.N_TMR(2)) i_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ovf_i (tmr_ovf_i),
    .clr_i (tmr_clr),
    .flag_o(tmr_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      idx_q <= '0;
      vec_q <= '0;
      svc_q <= SVC_IDLE;
    end else begin
      ack_q <= fire;
      if (fire) begin
        idx_q <= pick_idx;
        vec_q <= pick_vec;
        svc_q <= SVC_BUSY;
      end else if (reti_i) begin
        svc_q <= SVC_IDLE;
      end
    end
  end

  assign ack_o     = ack_q;
  assign ack_idx_o = idx_q;
  assign vec_o     = vec_q;
  assign in_svc_o  = (svc_q == SVC_BUSY);

  assert_ack_one_clk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_ack_needs_stb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(mc_stb_i));
  assert_ack_sets_svc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> in_svc_o);
  assert_no_ack_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o |=> !ack_o);
  assert_svc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_svc_o && !reti_i) |=> in_svc_o);
  assert_vec_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (vec_o == VEC_W'(VEC_BASE) + VEC_W'(ack_idx_o) * VEC_W'(VEC_STEP)));
  assert_glb_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_o) && ack_idx_o != IDX_W'(PF_IDX)) |-> $past(glb_en_i));
  assert_en_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(en_i[ack_idx_o]));
  assert_t0_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_o) && ack_idx_o == IDX_W'(T0_IDX) && !$past(tmr_ovf_i[0])) |-> !tmr_flag_o[0]);
endmodule

// File: tb/test_irq_dispatch_gate.sv
module test_irq_dispatch_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mc_stb_i = 1'b0;
  logic [6:0] req_i = '0;
  logic [1:0] tmr_ovf_i = '0;
  logic [6:0] en_i = '0;
  logic       glb_en_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       ack_o;
  logic [2:0] ack_idx_o;
  logic [15:0] vec_o;
  logic       in_svc_o;
  logic [1:0] tmr_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_dispatch_gate i_irq_dispatch_gate (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare every acknowledge with the scoreboard
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && ack_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected ack", int'(ack_idx_o), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(ack_idx_o == 3'(e), "R5 index", int'(ack_idx_o), e);
        chk(vec_o == 16'(3 + 8 * e), "R6 vector", int'(vec_o), 3 + 8 * e);
      end
    end
  end

  task automatic strobe(input int exp, input string req);
    @(negedge clk_i);
    if (exp >= 0) exp_q.push_back(exp);
    mc_stb_i = 1'b1;
    @(negedge clk_i);
    mc_stb_i = 1'b0;
    chk(ack_o == (exp >= 0), req, int'(ack_o), int'(exp >= 0));
    @(negedge clk_i);
    chk(ack_o == 1'b0, "R7 pulse width", int'(ack_o), 0);
  endtask

  task automatic reti_pulse();
    @(negedge clk_i); reti_i = 1'b1;
    @(negedge clk_i); reti_i = 1'b0;
    chk(in_svc_o == 1'b0, "R8 cleared by return", int'(in_svc_o), 0);
  endtask

  task automatic ovf(input logic [1:0] v);
    @(negedge clk_i); tmr_ovf_i = v;
    @(negedge clk_i); tmr_ovf_i = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ack_o == 1'b0, "R1 ack reset", int'(ack_o), 0);
    chk(in_svc_o == 1'b0, "R1 in_svc reset", int'(in_svc_o), 0);
    chk(tmr_flag_o == 2'b00, "R1 flags reset", int'(tmr_flag_o), 0);
    rst_ni = 1'b1;
    en_i = 7'h7F; glb_en_i = 1'b1;

    // R7: held request without strobe
    req_i = 7'b0000001;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      chk(ack_o == 1'b0, "R7 no strobe", int'(ack_o), 0);
    end
    strobe(0, "R7 external 0 dispatched");
    chk(in_svc_o == 1'b1, "R8 set by ack", int'(in_svc_o), 1);
    req_i = 7'b0000101;
    strobe(-1, "R8 blocked while busy");
    req_i = '0;
    reti_pulse();

    // R5: power-fail beats lower index
    req_i = 7'b1000001;
    strobe(6, "R5 power-fail first");
    req_i = '0; reti_pulse();

    // R5: lowest index among several
    req_i = 7'b0110100;
    strobe(2, "R5 lowest index");
    req_i[2] = 1'b0; reti_pulse();
    strobe(4, "R5 next serial");
    req_i[4] = 1'b0; reti_pulse();
    strobe(5, "R5 next rtc");
    req_i = '0; reti_pulse();

    // R2: individual enable
    en_i = 7'h6F; req_i = 7'b0010000;
    strobe(-1, "R2 disabled serial");
    req_i = '0; en_i = 7'h7F;

    // R3/R4: global enable
    glb_en_i = 1'b0; req_i = 7'b0100001;
    strobe(-1, "R3 global off");
    req_i = 7'b1100001; en_i = 7'h3F;
    strobe(-1, "R4 power-fail own enable off");
    en_i = 7'h7F;
    strobe(6, "R4 power-fail with global off");
    req_i = '0; reti_pulse();
    glb_en_i = 1'b1;

    // R9: timers
    req_i = 7'b0001010;
    strobe(-1, "R9 raw timer lines ignored");
    req_i = '0;
    ovf(2'b01);
    chk(tmr_flag_o == 2'b01, "R9 flag set", int'(tmr_flag_o), 1);
    strobe(1, "R9 timer 0 dispatched");
    chk(tmr_flag_o == 2'b00, "R9 timer 0 cleared", int'(tmr_flag_o), 0);
    reti_pulse();
    ovf(2'b11);
    strobe(1, "R9 timer 0 again");
    chk(tmr_flag_o == 2'b10, "R9 only timer 0 cleared", int'(tmr_flag_o), 2);
    reti_pulse();
    strobe(3, "R9 timer 1 dispatched");
    chk(tmr_flag_o == 2'b00, "R9 timer 1 cleared", int'(tmr_flag_o), 0);
    reti_pulse();

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R7 all expected acks seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule